// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This unit performs the shift and rotate step of a simple processor datapath. It takes a source operand, a shift amount and a 3-bit operation code. It produces a registered result for the destination register, a carry flag and a zero flag. Five operations are supported: logical shift left, logical shift right, arithmetic shift right, rotate left and rotate right. An arithmetic left shift is the same as a logical left shift, so it has no code of its own.

The next-state logic is combinational. Its outputs are captured on the rising clock edge, and only while the execute-enable input is high, so the flags change together with the result. The carry flag records the last bit that left the operand. For rotates, that bit is the one that wrapped around to the other end. The zero flag reports an all-zero result. The source operand is only read, never modified. The shift amount is clog2(W) bits wide, so it is taken modulo W.

Top module: `shift_rotate_unit`

## Requirements
- R1: After reset, result is 0, carry is 0 and zero is 1.
- R2: Code 000 (shift left) by n>0 moves bits toward the MSB and fills the n low positions with 0. Carry becomes src[W-n].
- R3: Code 001 (logical shift right) by n>0 fills the n high positions with 0. Carry becomes src[n-1].
- R4: Code 010 (arithmetic shift right) by n>0 fills the n high positions with copies of src[W-1]. Carry becomes src[n-1].
- R5: Code 011 (rotate left) by n>0 places the bits leaving the MSB end into the LSB end, so no bit is lost. Carry becomes the new result[0], which equals src[W-n].
- R6: Code 100 (rotate right) by n>0 places the bits leaving the LSB end into the MSB end. Carry becomes the new result[W-1], which equals src[n-1].
- R7: With codes 000 to 100 and a count of 0, the result equals src and carry keeps its previous value.
- R8: While exec_en is low, result, carry and zero all hold their values.
- R9: After an executed operation with codes 000 to 100, zero is 1 exactly when the new result is all zeros.
- R10: With codes 101, 110 and 111, the result is loaded with src unchanged, and carry and zero keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_en | input | 1 | Execute enable; outputs update only when high |
| op | input | 3 | Operation code |
| src | input | W | Source operand |
| count | input | clog2(W) | Shift or rotate amount |
| result | output | W | Registered result for the destination register |
| carry | output | 1 | Carry flag: last bit moved out or wrapped |
| zero | output | 1 | Zero flag |

## Verification
The properties assume three things about the inputs:
- op, src and count are stable and known at each rising edge.
- op is never X.
- exec_en is not toggled within a cycle.

The bench drives every input at the falling edge, so each one settles half a period before it is sampled. Expected values are checked one falling edge after the capturing edge. The stimulus includes:
- every valid and invalid code,
- count values of 0, 1 and W-1,
- operands with the sign bit set,
- cycles with the enable held low.

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit #(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 exec_en,
  input  logic [2:0]           op,
  input  logic [W-1:0]         src,
  input  logic [$clog2(W)-1:0] count,
  output logic [W-1:0]         result,
  output logic                 carry,
  output logic                 zero
);
  localparam int CW = $clog2(W);
  localparam logic [2:0] OP_SHL = 3'b000;
  localparam logic [2:0] OP_SHR = 3'b001;
  localparam logic [2:0] OP_SAR = 3'b010;
  localparam logic [2:0] OP_RTL = 3'b011;
  localparam logic [2:0] OP_RTR = 3'b100;

  logic [CW:0]   n_ext, n_back;
  logic [W-1:0]  shl_v, shr_v, sar_v, rtl_v, rtr_v;
  logic          bit_hi, bit_lo;
  logic [W-1:0]  nxt_res;
  logic          nxt_c, known_op;

  assign n_ext  = {1'b0, count};
  assign n_back = (CW+1)'(W) - n_ext;

  assign shl_v = src << count;
  assign shr_v = src >> count;
  assign sar_v = $signed(src) >>> count;
  assign rtl_v = (src << count) | (src >> n_back);
  assign rtr_v = (src >> count) | (src << n_back);

  assign bit_hi = src[n_back[CW-1:0]];
  assign bit_lo = src[count - 1'b1];

  always_comb begin
    known_op = 1'b1;
    nxt_res  = src;
    nxt_c    = carry;
    case (op)
      OP_SHL: begin nxt_res = shl_v; nxt_c = bit_hi; end
      OP_SHR: begin nxt_res = shr_v; nxt_c = bit_lo; end
      OP_SAR: begin nxt_res = sar_v; nxt_c = bit_lo; end
      OP_RTL: begin nxt_res = rtl_v; nxt_c = bit_hi; end
      OP_RTR: begin nxt_res = rtr_v; nxt_c = bit_lo; end
      default: known_op = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      carry  <= 1'b0;
      zero   <= 1'b1;
    end else if (exec_en) begin
      result <= nxt_res;
      if (known_op) begin
        zero <= (nxt_res == '0);
        if (count != '0) carry <= nxt_c;
      end
    end
  end
endmodule

module shift_rotate_unit_chk #(
  parameter int W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 exec_en,
  input logic [2:0]           op,
  input logic [W-1:0]         src,
  input logic [$clog2(W)-1:0] count,
  input logic [W-1:0]         result,
  input logic                 carry,
  input logic                 zero
);
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> $stable(result) && $stable(carry) && $stable(zero));

  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op <= 3'd4 |=> zero == (result == '0));

  assert_count0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op <= 3'd4 && count == '0 |=> $stable(carry) && result == $past(src));

  assert_bad_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op > 3'd4 |=> $stable(carry) && $stable(zero) && result == $past(src));

  assert_rot_keeps_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && (op == 3'd3 || op == 3'd4) |=> $countones(result) == $countones($past(src)));

  assert_shl_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op == 3'd0 && count != '0 |=> result[0] == 1'b0);

  assert_sar_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op == 3'd2 |=> result[W-1] == $past(src[W-1]));

  assert_rol_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op == 3'd3 && count != '0 |=> carry == result[0]);

  assert_ror_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op == 3'd4 && count != '0 |=> carry == result[W-1]);
endmodule

bind shift_rotate_unit shift_rotate_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op(op), .src(src),
  .count(count), .result(result), .carry(carry), .zero(zero)
);

// File: tb/shift_rotate_unit_bench.sv
module shift_rotate_unit_bench;
  localparam int W  = 32;
  localparam int CW = $clog2(W);

  typedef struct {
    logic [W-1:0] res;
    logic         c;
    logic         z;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exec_en = 1'b0;
  logic [2:0] op = '0;
  logic [W-1:0] src = '0;
  logic [CW-1:0] count = '0;
  logic [W-1:0] result;
  logic carry, zero;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  logic [W-1:0] m_res = '0;
  logic m_c = 1'b0, m_z = 1'b1;
  logic done = 1'b0;

  always #4 clk = ~clk;

  shift_rotate_unit #(.W(W)) u_shift_rotate_unit (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op(op), .src(src),
    .count(count), .result(result), .carry(carry), .zero(zero)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (result !== e.res || carry !== e.c || zero !== e.z) begin
      errors++;
      $display("FAIL %s: got res=%h c=%b z=%b expected res=%h c=%b z=%b",
               e.tag, result, carry, zero, e.res, e.c, e.z);
    end
  endtask

  task automatic step(input logic en, input logic [2:0] o, input logic [W-1:0] s,
                      input int n, input string tag);
    exp_t e;
    logic [W-1:0] r;
    logic c;
    @(negedge clk);
    exec_en = en; op = o; src = s; count = CW'(n);
    r = s; c = m_c;
    if (en) begin
      for (int i = 0; i < W; i++) begin
        case (o)
          3'd0: r[i] = (i >= n) ? s[i-n] : 1'b0;
          3'd1: r[i] = (i + n < W) ? s[i+n] : 1'b0;
          3'd2: r[i] = (i + n < W) ? s[i+n] : s[W-1];
          3'd3: r[i] = s[(i - n + W) % W];
          3'd4: r[i] = s[(i + n) % W];
          default: r[i] = s[i];
        endcase
      end
      if (n != 0 && o <= 3'd4) begin
        if (o == 3'd0 || o == 3'd3) c = s[W-n];
        else c = s[n-1];
      end
      m_res = r;
      m_c = c;
      if (o <= 3'd4) m_z = (r == '0);
    end
    e.res = m_res; e.c = m_c; e.z = m_z; e.tag = tag;
    @(posedge clk);
    #1 q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) compare(q.pop_front());
  end

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    exp_t e0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    e0.res = '0; e0.c = 1'b0; e0.z = 1'b1; e0.tag = "R1 reset";
    compare(e0);
    rst_n = 1'b1;

    step(1, 3'd0, 32'h8000_0001, 1,  "R2 shl by 1");
    step(1, 3'd0, 32'h0000_0002, 31, "R2 R9 shl to zero");
    step(1, 3'd1, 32'h8000_0001, 1,  "R3 shr by 1");
    step(1, 3'd1, 32'hF000_0000, 31, "R3 shr by W-1");
    step(1, 3'd2, 32'h8000_0010, 4,  "R4 sar negative");
    step(1, 3'd2, 32'h4000_0000, 31, "R4 R9 sar positive");
    step(1, 3'd3, 32'h8000_0000, 1,  "R5 rol wrap");
    step(1, 3'd3, 32'h1234_5678, 8,  "R5 rol by 8");
    step(1, 3'd4, 32'h0000_0001, 1,  "R6 ror wrap");
    step(1, 3'd4, 32'h1234_5678, 31, "R6 ror by W-1");
    step(1, 3'd0, 32'h0000_0000, 0,  "R7 R9 count0 zero");
    step(1, 3'd1, 32'hDEAD_BEEF, 0,  "R7 count0 keeps carry");
    step(0, 3'd0, 32'hFFFF_FFFF, 5,  "R8 enable low");
    step(0, 3'd3, 32'h0000_0000, 3,  "R8 enable low again");
    step(1, 3'd0, 32'h0000_0001, 31, "R2 carry clear setup");
    step(1, 3'd5, 32'h0000_0000, 3,  "R10 code 101");
    step(1, 3'd6, 32'hABCD_0000, 7,  "R10 code 110");
    step(1, 3'd7, 32'h0000_0000, 1,  "R10 code 111");
    begin
      logic [W-1:0] v = 32'h1357_9BDF;
      for (int k = 0; k < 200; k++) begin
        v = v * 32'd1664525 + 32'd1013904223;
        step(1'(k % 11 != 0), 3'(v[31:29]), v ^ {v[7:0], 24'h0}, int'(v[12:8]),
             "R2 R3 R4 R5 R6 R9 R10 mixed");
      end
    end
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule